// File: doc/BRIEF.md
# Five-to-Two Carry-Save Compressor Row

This block is a purely combinational reduction stage for a wide adder tree. It accepts five addend vectors of `W` bits each and folds them into one sum vector and one carry vector, plus two overflow bits above the top position. A downstream carry-propagate adder then adds the sum vector and the left-shifted carry vector to get the total. Typical use is inside a partial-product reduction tree, where five rows of equal weight must become two.

Each bit position holds one cell. A cell takes the five operand bits of its own weight and two carry bits from the cell one position below. It produces a sum bit of its own weight and three bits of the next higher weight: a carry bit and two forward carries. The forward carries feed the cell above. They are derived from the five operand bits alone, so a carry entering a cell never ripples through it into the next cell. Inside the cell, the incoming carries pass only through a half-adder XOR and one select stage. The lowest cell receives constant-zero carries. The top cell's forward carries leave the block as the two overflow bits.

Top module: `cmp52_row`

## Requirements
- R1: In every cell, the sum bit equals the XOR of the five operand bits and the two incoming carries.
- R2: In every cell, the first forward carry equals operand 5 when operands 1 to 4 have odd parity, and operand 4 otherwise.
- R3: In every cell, the second forward carry is 1 exactly when at least two of operands 1, 2 and 3 are 1.
- R4: In every cell, the carry bit is 1 exactly when at least two of these are 1: the parity of operands 1 to 5, incoming carry 1, incoming carry 2.
- R5: For every cell, the count of ones over its seven inputs equals sum + 2·(carry + forward carry 1 + forward carry 2).
- R6: A cell's forward carries do not change when only its incoming carries change.
- R7: Forward carry 1 of cell i drives incoming carry 1 of cell i+1, and forward carry 2 drives incoming carry 2. Cell 0 sees zero incoming carries. The top cell's forward carries appear on `topCout1` and `topCout2`. With all operands zero, every output is zero.
- R8: For any operands, opA+opB+opC+opD+opE = sumVec + 2·carryVec + 2^W·(topCout1 + topCout2). Bit i of carryVec weighs 2^(i+1).
- R9: With all five operands all-ones, sumVec is all-ones, carryVec is all-ones except bit 0, and both top carries are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | W | Addend vector 1 (operand 1 of each cell) |
| opB | input | W | Addend vector 2 (operand 2 of each cell) |
| opC | input | W | Addend vector 3 (operand 3 of each cell) |
| opD | input | W | Addend vector 4 (operand 4 of each cell) |
| opE | input | W | Addend vector 5 (operand 5 of each cell) |
| sumVec | output | W | Sum bits, bit i of weight 2^i |
| carryVec | output | W | Carry bits, bit i of weight 2^(i+1) |
| topCout1 | output | 1 | First forward carry of the top cell, weight 2^W |
| topCout2 | output | 1 | Second forward carry of the top cell, weight 2^W |

## Verification
The bench builds the row with W = 16. This width lets directed walking patterns put a lone carry chain at the bottom, in the middle and at the top boundary, where the chain exits through the overflow bits. Randomized operands at this width check the weighted-sum identity over values far beyond any single cell. A separate single-cell instance, built with its default settings, is swept through all 128 combinations of its seven inputs. That sweep checks each output equation and confirms that the forward carries ignore the incoming carries.

// File: rtl/cmp52_pkg.sv
package cmp52_pkg;

  // Results of the operand-only stage of one cell
  typedef struct packed {
    logic par4;    // parity of operands 1..4
    logic par5;    // parity of operands 1..5
    logic fwd1;    // forward carry 1
    logic fwd2;    // forward carry 2
  } opndStage_t;

  // Results of the horizontal stage of one cell
  typedef struct packed {
    logic sumBit;
    logic carryBit;
  } horizStage_t;

  function automatic opndStage_t opndStage(input logic [4:0] ops);
    opndStage_t r;
    r.par4 = ops[0] ^ ops[1] ^ ops[2] ^ ops[3];
    r.par5 = r.par4 ^ ops[4];
    r.fwd1 = r.par4 ? ops[4] : ops[3];
    r.fwd2 = (ops[0] ^ ops[1]) ? ops[2] : ops[0];
    return r;
  endfunction

  // Half adder on the incoming carries, then one select
  function automatic horizStage_t horizStage(input logic par5,
                                             input logic cinA,
                                             input logic cinB);
    horizStage_t r;
    logic haX;
    haX        = cinA ^ cinB;
    r.sumBit   = par5 ^ haX;
    r.carryBit = haX ? par5 : cinA;
    return r;
  endfunction

endpackage

// File: rtl/cmp52_cell.sv
module cmp52_cell
  import cmp52_pkg::*;
(
  input  logic [4:0] ops,
  input  logic       cinA,
  input  logic       cinB,
  output logic       sumO,
  output logic       carryO,
  output logic       coutA,
  output logic       coutB
);

  opndStage_t  opnd;
  horizStage_t horiz;

  always_comb begin
    opnd   = opndStage(ops);
    horiz  = horizStage(opnd.par5, cinA, cinB);
    sumO   = horiz.sumBit;
    carryO = horiz.carryBit;
    coutA  = opnd.fwd1;
    coutB  = opnd.fwd2;

    // R1: sum bit is the parity of all seven inputs
    p_sum_parity_r1: assert ((^{ops, cinA, cinB}) == horiz.sumBit);
    // R2: forward carry 1 is 1 only if operand 4 or 5 could supply it
    p_fwd1_src_r2: assert (!opnd.fwd1 || ops[3] || ops[4]);
    // R3: forward carry 2 agrees with a majority count of operands 1..3
    p_fwd2_maj_r3: assert (opnd.fwd2 == ($countones(ops[2:0]) >= 2));
    // R4: carry bit is 1 only if at least one incoming carry is 1
    p_carry_src_r4: assert (!horiz.carryBit || cinA || cinB);
    // R5: weight is preserved across the cell
    p_weight_r5: assert ($countones({ops, cinA, cinB}) ==
                         {2'b00, horiz.sumBit} +
                         3'd2 * ({2'b00, horiz.carryBit} + {2'b00, opnd.fwd1} +
                                 {2'b00, opnd.fwd2}));
  end

endmodule

// File: rtl/cmp52_row.sv
module cmp52_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] opC,
  input  logic [W-1:0] opD,
  input  logic [W-1:0] opE,
  output logic [W-1:0] sumVec,
  output logic [W-1:0] carryVec,
  output logic         topCout1,
  output logic         topCout2
);

  localparam int NLINK = W + 1;

  // link[i] carries into cell i; link[W] leaves the block (R7)
  logic [NLINK-1:0] linkA;
  logic [NLINK-1:0] linkB;

  assign linkA[0] = 1'b0;
  assign linkB[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    cmp52_cell cell_i (
      .ops    ({opE[i], opD[i], opC[i], opB[i], opA[i]}),
      .cinA   (linkA[i]),
      .cinB   (linkB[i]),
      .sumO   (sumVec[i]),
      .carryO (carryVec[i]),
      .coutA  (linkA[i+1]),
      .coutB  (linkB[i+1])
    );
  end

  assign topCout1 = linkA[W];
  assign topCout2 = linkB[W];

endmodule

// File: tb/cmp52_row_tb.sv
module cmp52_row_tb_top;

  localparam int W = 16;
  localparam int WX = W + 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int total = 0;
  int bad = 0;

  logic [W-1:0] opA, opB, opC, opD, opE, sumVec, carryVec;
  logic topCout1, topCout2;

  cmp52_row #(.W(W)) dut_i (
    .opA(opA), .opB(opB), .opC(opC), .opD(opD), .opE(opE),
    .sumVec(sumVec), .carryVec(carryVec),
    .topCout1(topCout1), .topCout2(topCout2)
  );

  logic [4:0] cOps;
  logic cCinA, cCinB, cSum, cCarry, cCoutA, cCoutB;

  cmp52_cell cell_i (
    .ops(cOps), .cinA(cCinA), .cinB(cCinB),
    .sumO(cSum), .carryO(cCarry), .coutA(cCoutA), .coutB(cCoutB)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic applyRow(input logic [W-1:0] a, b, c, d, e);
    @(negedge clk);
    opA = a; opB = b; opC = c; opD = d; opE = e;
    #1;
  endtask

  task automatic t_cellSweep();
    logic [1:0] coutsAtZero [32];
    for (int v = 0; v < 128; v++) begin
      logic [6:0] bits;
      int ones;
      logic ex1, ex2, exCarry, p4, p5;
      bits = v[6:0];
      @(negedge clk);
      cOps = bits[4:0]; cCinA = bits[5]; cCinB = bits[6];
      #1;
      ones = $countones(bits);
      p4 = bits[0] ^ bits[1] ^ bits[2] ^ bits[3];
      p5 = p4 ^ bits[4];
      ex1 = p4 ? bits[4] : bits[3];
      ex2 = (int'(bits[0]) + int'(bits[1]) + int'(bits[2])) >= 2;
      exCarry = (int'(p5) + int'(bits[5]) + int'(bits[6])) >= 2;
      chk(cSum == ^bits, "R1 cell sum", cSum, ^bits);
      chk(cCoutA == ex1, "R2 cell fwd1", cCoutA, ex1);
      chk(cCoutB == ex2, "R3 cell fwd2", cCoutB, ex2);
      chk(cCarry == exCarry, "R4 cell carry", cCarry, exCarry);
      chk(ones == int'(cSum) + 2 * (int'(cCarry) + int'(cCoutA) + int'(cCoutB)),
          "R5 cell weight", int'(cSum) + 2 * (int'(cCarry) + int'(cCoutA) + int'(cCoutB)), ones);
      if (v < 32) coutsAtZero[v] = {cCoutA, cCoutB};
      else chk({cCoutA, cCoutB} == coutsAtZero[v % 32], "R6 fwd carries ignore cin",
               {cCoutA, cCoutB}, coutsAtZero[v % 32]);
    end
  endtask

  task automatic t_rowZero();
    applyRow('0, '0, '0, '0, '0);
    chk(sumVec == '0 && carryVec == '0 && !topCout1 && !topCout2, "R7 all-zero row",
        {topCout1, topCout2, carryVec, sumVec}, 0);
  endtask

  task automatic t_rowChain();
    int ks [3] = '{0, 7, W-1};
    foreach (ks[j]) begin
      logic [W-1:0] m, eSum, eCar;
      logic eHi1, eHi2;
      int k;
      k = ks[j];
      m = '0; m[k] = 1'b1;
      // three ones at bit k: sum at k, second forward carry feeds bit k+1
      applyRow(m, m, m, '0, '0);
      eSum = m; eHi2 = (k == W-1);
      if (k < W-1) eSum[k+1] = 1'b1;
      chk(sumVec == eSum && carryVec == '0 && !topCout1 && topCout2 == eHi2,
          "R7 chain via carry 2", {topCout1, topCout2, carryVec, sumVec},
          {1'b0, eHi2, {W{1'b0}}, eSum});
      // four ones at bit k: both forward carries feed bit k+1
      applyRow(m, m, m, m, '0);
      eCar = '0; eHi1 = (k == W-1);
      if (k < W-1) eCar[k+1] = 1'b1;
      chk(sumVec == '0 && carryVec == eCar && topCout1 == eHi1 && topCout2 == eHi1,
          "R7 chain via both carries", {topCout1, topCout2, carryVec, sumVec},
          {eHi1, eHi1, eCar, {W{1'b0}}});
    end
  endtask

  task automatic t_rowOnes();
    logic [W-1:0] eCar;
    eCar = '1; eCar[0] = 1'b0;
    applyRow('1, '1, '1, '1, '1);
    chk(sumVec == '1 && carryVec == eCar && topCout1 && topCout2, "R9 all-ones row",
        {topCout1, topCout2, carryVec, sumVec}, {2'b11, eCar, {W{1'b1}}});
  endtask

  task automatic t_rowRandom();
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] r [5];
      logic [WX-1:0] exp, act;
      foreach (r[q]) r[q] = W'($urandom);
      if (n == 0) r[2] = '1;
      applyRow(r[0], r[1], r[2], r[3], r[4]);
      exp = WX'(r[0]) + WX'(r[1]) + WX'(r[2]) + WX'(r[3]) + WX'(r[4]);
      act = WX'(sumVec) + (WX'(carryVec) << 1) +
            ((WX'(topCout1) + WX'(topCout2)) << W);
      chk(act == exp, "R8 row weighted sum", act, exp);
    end
  endtask

  initial begin
    opA = '0; opB = '0; opC = '0; opD = '0; opE = '0;
    cOps = '0; cCinA = 1'b0; cCinB = 1'b0;
    t_rowZero();
    t_cellSweep();
    t_rowChain();
    t_rowOnes();
    t_rowRandom();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule